// File: doc/BRIEF.md
# Legacy Interrupt Vector Read Port

This block gives a processor a single-read answer to the question "which legacy interrupt line should be serviced next". It watches the request and mask bytes of two cascaded 8-line interrupt controllers. From them it works out the highest-priority line that is both requesting and unmasked. The processor can then skip the slow sequence of polling each controller through its own command ports.

The block has a plain strobe interface. A read strobe captures the encoded result, which appears one cycle later with a one-cycle valid pulse. The result is the line number plus 0x20, zero-extended to a 32-bit word. If no line qualifies, the word reads 0x20 and a spurious flag is raised. The port is read-only: a write strobe changes nothing except a one-cycle write-error pulse.

The controllers themselves are outside this block, and so is any acknowledge cycle.

Top module: `isa_irq_vector`

## Requirements
- R1: A line is active only when its request bit is 1 and its mask bit is 0. A requesting but masked line is never reported.
- R2: Primary controller bit k maps to line k (k = 0..7). Secondary controller bit k maps to line 8+k.
- R3: Line 2 is the cascade input and is never reported, even when it is requesting and unmasked.
- R4: When several lines are active, the lowest-numbered one is reported.
- R5: A read strobe (`rd_en`=1 with `wr_en`=0) at a clock edge produces `rd_valid`=1 for exactly one cycle after that edge. In that same cycle `rd_data` equals 0x20 plus the 4-bit winning line number, with bits 31..8 at zero.
- R6: When no line is active at the read strobe, `rd_data` is 0x20 and `spurious` is 1. When a line is reported, `spurious` is 0.
- R7: A write strobe (`wr_en`=1, which overrides a simultaneous `rd_en`) raises `wr_err` for exactly the one cycle after the edge. It leaves `rd_data` and `spurious` unchanged and produces no `rd_valid`.
- R8: Between read strobes, `rd_data` and `spurious` hold their last captured values, whatever the request and mask inputs do.
- R9: While `rst_n` is low at a clock edge, `rd_data`, `rd_valid`, `spurious` and `wr_err` all clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (always rejected) |
| pri_req | input | 8 | Primary controller request bits, lines 0..7 |
| pri_mask | input | 8 | Primary controller mask bits, 1 = masked |
| sec_req | input | 8 | Secondary controller request bits, lines 8..15 |
| sec_mask | input | 8 | Secondary controller mask bits, 1 = masked |
| rd_data | output | 32 | Encoded vector word captured on the last read |
| rd_valid | output | 1 | One-cycle pulse marking fresh read data |
| spurious | output | 1 | Last read found no active line |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
Some behaviours are checked on every cycle by the embedded properties:
- the one-cycle read and write pulses;
- the zero upper bytes of the result word;
- the hold of the captured result between reads;
- the absence of the cascade line from any encoded result;
- the lowest-line-wins rule, checked against the merged active vector.

Other behaviours need the bench's scenarios to show them:
- that the right controller bit lands on the right line;
- that masking actually suppresses a request;
- that the empty case produces exactly 0x20 with the spurious flag;
- that a write leaves an earlier result intact.

Those checks compare every read against a model built independently from the request and mask bytes.

// File: rtl/isa_vec_pkg.sv
// Package: shared constants and the read-result record for the legacy
// interrupt vector port.
// Assumes: two controllers of equal width, cascade on a primary line.
package isa_vec_pkg;

    localparam int unsigned CTRL_LINES_DEF = 8;
    localparam int unsigned CASCADE_DEF    = 2;
    localparam logic [7:0]  VEC_BASE_DEF   = 8'h20;
    localparam int unsigned BUS_W_DEF      = 32;

    // Encoded answer as produced by the scan path, before capture.
    typedef struct packed {
        logic [7:0] code;
        logic       none;
    } vec_result_t;

endpackage

// File: rtl/irq_line_merge.sv
// Module: irq_line_merge
// Merges the request and mask bytes of both controllers into a single
// vector of qualifying lines, numbered primary first. The cascade line is
// removed here so later stages never see it.
// Assumes: mask bit 1 means masked; cascade index lies in the primary.
module irq_line_merge #(
    parameter int unsigned CTRL_LINES = 8,
    parameter int unsigned CASCADE    = 2,
    localparam int unsigned N_LINES   = 2 * CTRL_LINES
) (
    input  logic [CTRL_LINES-1:0] pri_req,
    input  logic [CTRL_LINES-1:0] pri_mask,
    input  logic [CTRL_LINES-1:0] sec_req,
    input  logic [CTRL_LINES-1:0] sec_mask,
    output logic [N_LINES-1:0]    active
);

    logic [N_LINES-1:0] raw_active;

    // Qualify each controller's lines: requesting and not masked.
    assign raw_active = {sec_req & ~sec_mask, pri_req & ~pri_mask};

    // Drop the cascade line; every other line passes through unchanged.
    for (genvar g = 0; g < N_LINES; g++) begin : g_lane
        if (g == CASCADE) begin : g_casc
            assign active[g] = 1'b0;
        end else begin : g_pass
            assign active[g] = raw_active[g];
        end
    end

endmodule

// File: rtl/irq_prio_scan.sv
// Module: irq_prio_scan
// Fixed-priority scan over the merged active vector. The lowest index
// wins. Builds a one-hot grant through a ripple "lower line seen" chain,
// then folds it into a binary index.
// Assumes: purely combinational; index is 0 when nothing is active.
module irq_prio_scan #(
    parameter int unsigned N_LINES = 16,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] active,
    output logic [N_LINES-1:0] grant,
    output logic [IDX_W-1:0]   win_idx,
    output logic               found
);

    logic [N_LINES-1:0] lower_seen;

    // Ripple chain: each lane learns whether any lower lane is active.
    for (genvar g = 0; g < N_LINES; g++) begin : g_chain
        if (g == 0) begin : g_first
            assign lower_seen[g] = 1'b0;
        end else begin : g_rest
            assign lower_seen[g] = lower_seen[g-1] | active[g-1];
        end
        assign grant[g] = active[g] & ~lower_seen[g];
    end

    // Any active lane means a winner exists.
    assign found = |active;

    // Fold the one-hot grant into a binary line number.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (grant[i]) win_idx = win_idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_vec_port.sv
// Module: irq_vec_port
// Strobe interface. A read captures the encoded vector and the empty flag
// one cycle after the strobe. A write is rejected and only pulses an error.
// Assumes: wr_en overrides rd_en in the same cycle; synchronous reset.
module irq_vec_port
    import isa_vec_pkg::*;
#(
    parameter int unsigned N_LINES  = 16,
    parameter int unsigned CASCADE  = 2,
    parameter logic [7:0]  VEC_BASE = 8'h20,
    parameter int unsigned BUS_W    = 32,
    localparam int unsigned IDX_W   = $clog2(N_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             found,
    output logic [BUS_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             spurious,
    output logic             wr_err
);

    vec_result_t next_res;
    logic        rd_take;

    // Offset the winning index by the vector base; index is 0 when empty.
    always_comb begin
        next_res.code = VEC_BASE + 8'(win_idx);
        next_res.none = ~found;
    end

    // A read counts only when no write shares the cycle.
    assign rd_take = rd_en & ~wr_en;

    // Capture the result on a read; pulse valid and write-error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            spurious <= 1'b0;
            wr_err   <= 1'b0;
        end else begin
            rd_valid <= rd_take;
            wr_err   <= wr_en;
            if (rd_take) begin
                rd_data  <= BUS_W'(next_res.code);
                spurious <= next_res.none;
            end
        end
    end

    // R3
    cascade_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (win_idx != IDX_W'(CASCADE)));

    // R5
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> (rd_valid && rd_data[BUS_W-1:8] == '0));

    // R6
    empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && spurious) |-> (rd_data == BUS_W'(VEC_BASE)));

    // R7
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_err && !rd_valid));

    // R8
    hold_between_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> ($stable(rd_data) && $stable(spurious)));

endmodule

// File: rtl/isa_irq_vector.sv
// Module: isa_irq_vector (top)
// Read-only port that reports the highest-priority pending, unmasked line
// of two cascaded 8-line interrupt controllers as 0x20 + line number.
// Assumes: controller request/mask bytes are stable in the clock domain.
module isa_irq_vector
    import isa_vec_pkg::*;
#(
    parameter int unsigned CTRL_LINES = CTRL_LINES_DEF,
    parameter int unsigned CASCADE    = CASCADE_DEF,
    parameter logic [7:0]  VEC_BASE   = VEC_BASE_DEF,
    parameter int unsigned BUS_W      = BUS_W_DEF,
    localparam int unsigned N_LINES   = 2 * CTRL_LINES,
    localparam int unsigned IDX_W     = $clog2(N_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [CTRL_LINES-1:0] pri_req,
    input  logic [CTRL_LINES-1:0] pri_mask,
    input  logic [CTRL_LINES-1:0] sec_req,
    input  logic [CTRL_LINES-1:0] sec_mask,
    output logic [BUS_W-1:0]      rd_data,
    output logic                  rd_valid,
    output logic                  spurious,
    output logic                  wr_err
);

    logic [N_LINES-1:0] active;
    logic [N_LINES-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               found;

    irq_line_merge #(.CTRL_LINES(CTRL_LINES), .CASCADE(CASCADE)) u_merge (
        .pri_req (pri_req),
        .pri_mask(pri_mask),
        .sec_req (sec_req),
        .sec_mask(sec_mask),
        .active  (active)
    );

    irq_prio_scan #(.N_LINES(N_LINES)) u_scan (
        .active (active),
        .grant  (grant),
        .win_idx(win_idx),
        .found  (found)
    );

    irq_vec_port #(
        .N_LINES(N_LINES), .CASCADE(CASCADE),
        .VEC_BASE(VEC_BASE), .BUS_W(BUS_W)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .win_idx (win_idx),
        .found   (found),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .spurious(spurious),
        .wr_err  (wr_err)
    );

    // R4
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (active[win_idx] &&
                   ((active & ((N_LINES'(1) << win_idx) - N_LINES'(1))) == '0)));

    // R4
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (found == (grant != '0)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !rd_valid && !spurious && !wr_err));

endmodule

// File: tb/sim_isa_irq_vector.sv
// Scoreboard bench: the driver pushes expected read results, and the
// monitor pops and compares them when rd_valid pulses.
module sim_isa_irq_vector;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  pri_req = '0, pri_mask = '0, sec_req = '0, sec_mask = '0;
    logic [31:0] rd_data;
    logic        rd_valid, spurious, wr_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] data;
        logic        spur;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] last_data = '0;
    logic        last_spur = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_irq_vector u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .pri_req(pri_req), .pri_mask(pri_mask),
        .sec_req(sec_req), .sec_mask(sec_mask),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .spurious(spurious), .wr_err(wr_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Independent model: scan lines 0..15, skip line 2, lowest active wins.
    function automatic exp_t model(input logic [7:0] pr, input logic [7:0] pm,
                                   input logic [7:0] sr, input logic [7:0] sm,
                                   input string tag);
        exp_t e;
        e.data = 32'h20;
        e.spur = 1'b1;
        e.tag  = tag;
        for (int i = 15; i >= 0; i--) begin
            bit a;
            if (i == 2) continue;
            a = (i < 8) ? (pr[i] & ~pm[i]) : (sr[i-8] & ~sm[i-8]);
            if (a) begin
                e.data = 32'h20 + 32'(i);
                e.spur = 1'b0;
            end
        end
        return e;
    endfunction

    // Driver: apply inputs with a read strobe, push the expected result.
    task automatic do_read(input logic [7:0] pr, input logic [7:0] pm,
                           input logic [7:0] sr, input logic [7:0] sm,
                           input string tag);
        exp_t e;
        @(negedge clk);
        pri_req = pr; pri_mask = pm; sec_req = sr; sec_mask = sm;
        rd_en = 1'b1;
        wr_en = 1'b0;
        e = model(pr, pm, sr, sm, tag);
        sb_q.push_back(e);
        last_data = e.data;
        last_spur = e.spur;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_en = 1'b0;
            wr_en = 1'b0;
        end
    endtask

    // Monitor: on each valid pulse, pop and compare against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5 unexpected rd_valid", rd_data, 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rd_data == e.data, e.tag, rd_data, e.data);
                check(spurious == e.spur, {e.tag, " R6 spurious"},
                      32'(spurious), 32'(e.spur));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;

        // R9: outputs cleared during reset
        repeat (3) @(negedge clk);
        check(rd_data == 0 && !rd_valid && !spurious && !wr_err, "R9 reset state",
              {rd_data[28:0], rd_valid, spurious, wr_err}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        do_read(8'h01, 8'h00, 8'h00, 8'h00, "R5 line0 -> 0x20");
        do_read(8'h04, 8'h00, 8'h00, 8'h00, "R3 cascade only -> empty");
        do_read(8'h24, 8'h00, 8'h00, 8'h00, "R3 cascade skipped -> 0x25");
        do_read(8'h00, 8'h00, 8'h01, 8'h00, "R2 sec bit0 -> 0x28");
        do_read(8'h00, 8'h00, 8'h80, 8'h00, "R2 sec bit7 -> 0x2F");
        do_read(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R1 all masked -> empty");
        do_read(8'h08, 8'h08, 8'h10, 8'h00, "R1 masked line3, sec4 -> 0x2C");
        do_read(8'h80, 8'h00, 8'h01, 8'h00, "R4 line7 beats line8 -> 0x27");
        do_read(8'hF8, 8'h30, 8'hFF, 8'h00, "R4 lowest of many -> 0x23");
        do_read(8'h00, 8'h00, 8'h00, 8'h00, "R6 nothing pending -> 0x20");
        idle(2);

        // R8: inputs change without a strobe; captured result must hold
        @(negedge clk);
        pri_req = 8'h02; sec_req = 8'h40;
        idle(3);
        check(rd_data == last_data && spurious == last_spur, "R8 hold without read",
              rd_data, last_data);

        // R7: write with a simultaneous read is rejected
        do_read(8'h40, 8'h00, 8'h00, 8'h00, "R5 line6 -> 0x26");
        idle(2);
        @(negedge clk);
        pri_req = 8'h01; pri_mask = 8'h00;
        wr_en = 1'b1;
        rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check(wr_err == 1'b1, "R7 wr_err pulse", 32'(wr_err), 32'h1);
        check(rd_valid == 1'b0, "R7 no rd_valid on write", 32'(rd_valid), 32'h0);
        check(rd_data == 32'h26 && !spurious, "R7 data untouched by write",
              rd_data, 32'h26);
        @(negedge clk);
        check(wr_err == 1'b0, "R7 wr_err one cycle", 32'(wr_err), 32'h0);

        // R4: pseudo-random patterns, back-to-back reads
        lfsr = 32'hACE1_1357;
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            do_read(lfsr[7:0], lfsr[15:8] | lfsr[23:16], lfsr[23:16],
                    lfsr[31:24], "R4 random pattern");
        end
        idle(3);

        check(sb_q.size() == 0, "R5 all reads answered", 32'(sb_q.size()), 32'h0);

        // R9: reset after activity clears everything
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        check(rd_data == 0 && !spurious && !rd_valid && !wr_err, "R9 re-reset",
              rd_data, 32'h0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule